// File: doc/BRIEF.md
# Boot Configuration Image Loader

This block fills a configuration RAM once after every reset. It first writes zero to every RAM location. It then reads a four-byte header from an attached byte-addressed non-volatile memory, through a request/acknowledge read port. If the header carries the expected two-byte signature, the block streams the image body into the RAM region that starts at a fixed base address. If the signature is missing, it writes a short built-in default table into that region instead.

When the last byte has been written, the block raises a done level and a one-cycle update pulse. The pulse is intended to trigger the plug-and-play logic to reload its resource data. The block also presents the resource-data length that applies to the chosen path. On the image path that length comes from the header, stored high byte first and limited to a maximum. On the default path it is a fixed value. The serial-bus transaction layer of the memory is not part of this block; the read port stands for it at byte level.

Top module: `cfg_image_loader`

## Requirements
- R1: After reset is released the block writes 8'h00 to every RAM address from 0 up to RAM_DEPTH-1 in ascending order, one write per cycle, before it issues any memory read. Until done, res_len reads 0.
- R2: The header is read from memory offsets 0, 1, 2 and 3 in that order. A read is requested by ee_req with ee_addr, and it completes in the cycle in which ee_ack is high, with ee_data valid in that cycle. While ee_req is high and ee_ack is low, ee_addr stays stable. Successive completed reads use consecutive addresses.
- R3: The image is valid when offset 0 holds 8'h55 and offset 1 holds 8'hBB. In that case the memory bytes from offset 4 onward are written to RAM addresses IMG_BASE, IMG_BASE+1 and so on. The number of bytes copied is the smaller of EE_DEPTH-4 and RAM_DEPTH-IMG_BASE, and no other memory offset is read.
- R4: For a valid image, res_len equals the 16-bit value {offset 2, offset 3}, with offset 2 as the high byte, limited to RES_MAX (default 384).
- R5: When the signature is absent, no memory byte beyond offset 3 is read. The eight bytes 55 BB 00 00 00 03 80 80 (hex) are written at IMG_BASE through IMG_BASE+7, and res_len equals DEF_RES_LEN (default 19).
- R6: The done output rises in the cycle after the final RAM write and stays high until the next reset. upd_pulse is high for exactly that first done cycle. While done is high there are no RAM writes and no memory requests.
- R7: The signature check needs both bytes. A correct first byte with a wrong second byte, or the two bytes swapped, takes the default path.
- R8: ee_addr never reaches EE_DEPTH while ee_req is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low; its release starts a load |
| ee_req | output | 1 | Memory byte-read request |
| ee_addr | output | EE_AW | Memory byte offset of the request |
| ee_ack | input | 1 | Read completes in this cycle |
| ee_data | input | 8 | Read data, valid with ee_ack |
| ram_we | output | 1 | RAM byte write strobe |
| ram_addr | output | RAM_AW | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| res_len | output | 16 | Resource-data length; 0 until done |
| done | output | 1 | Load finished (sticky until reset) |
| upd_pulse | output | 1 | One-cycle resource-update trigger |

## Verification
The hardest situations to reach are the boundaries of the header decision: a signature that is correct in only one byte, and lengths on either side of the limit. Reaching them needs a full reset-and-load cycle for each header. Each directed task therefore rewrites the bench's memory model, pulses reset and replays the whole load. Small parameters (a 256-byte RAM with the image base near its top) keep each load short. They also make the RAM region, not the memory size, set the copy count, so over-reading shows up as extra completed reads. The acknowledge latency is varied across tasks, so that the address-hold rule is exercised with waiting requests.

// File: rtl/cfg_image_loader_pkg.sv
package cfg_image_loader_pkg;

   typedef enum logic [2:0] {
      ST_BOOT,
      ST_CLEAR,
      ST_HDR,
      ST_COPY,
      ST_DEF,
      ST_FIN,
      ST_DONE
   } ld_state_t;

   localparam int unsigned HDR_BYTES = 4;
   localparam int unsigned DEF_LEN   = 8;
   localparam int unsigned DEF_IW    = $clog2(DEF_LEN);
   localparam logic [7:0]  SIG_B0    = 8'h55;
   localparam logic [7:0]  SIG_B1    = 8'hBB;

   // Built-in fallback configuration bytes.
   function automatic logic [7:0] def_byte(input logic [DEF_IW-1:0] idx);
      logic [7:0] b;
      case (idx)
         3'd0:    b = 8'h55;
         3'd1:    b = 8'hBB;
         3'd5:    b = 8'h03;
         3'd6:    b = 8'h80;
         3'd7:    b = 8'h80;
         default: b = 8'h00;
      endcase
      return b;
   endfunction

endpackage

// File: rtl/cfg_hdr_capture.sv
module cfg_hdr_capture
   import cfg_image_loader_pkg::*;
#(
   parameter int unsigned RES_MAX = 384
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cap_en,
   input  logic [1:0]  cap_idx,
   input  logic [7:0]  cap_data,
   output logic        sig_ok,
   output logic [15:0] len_lim
);

   logic [7:0]  hdr_q [HDR_BYTES];
   logic [15:0] len_raw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < int'(HDR_BYTES); k++) hdr_q[k] <= 8'h00;
      end else if (cap_en) begin
         hdr_q[cap_idx] <= cap_data;
      end
   end

   assign sig_ok  = (hdr_q[0] == SIG_B0) && (hdr_q[1] == SIG_B1);
   assign len_raw = {hdr_q[2], hdr_q[3]};

   generate
      if (RES_MAX >= 65535) begin : g_no_limit
         assign len_lim = len_raw;
      end else begin : g_limit
         localparam logic [15:0] LIM = 16'(RES_MAX);
         assign len_lim = (len_raw > LIM) ? LIM : len_raw;
      end
   endgenerate

endmodule

// File: rtl/cfg_def_table.sv
module cfg_def_table
   import cfg_image_loader_pkg::*;
(
   input  logic [DEF_IW-1:0] idx,
   output logic [7:0]        data
);

   assign data = def_byte(idx);

endmodule

// File: rtl/cfg_load_seq.sv
module cfg_load_seq
   import cfg_image_loader_pkg::*;
#(
   parameter int unsigned EE_AW    = 14,
   parameter int unsigned RAM_AW   = 15,
   parameter int unsigned IMG_BASE = 16384,
   parameter int unsigned COPY_LEN = 8220
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              ee_req,
   output logic [EE_AW-1:0]  ee_addr,
   input  logic              ee_ack,
   input  logic [7:0]        ee_data,
   output logic              hdr_cap_en,
   output logic [1:0]        hdr_cap_idx,
   input  logic              sig_ok,
   output logic [DEF_IW-1:0] def_idx,
   input  logic [7:0]        def_data,
   output logic              ram_we,
   output logic [RAM_AW-1:0] ram_addr,
   output logic [7:0]        ram_wdata,
   output logic              img_path,
   output logic              fin,
   output logic              done
);

   localparam int unsigned       RAM_DEPTH = 1 << RAM_AW;
   localparam int unsigned       CW        = RAM_AW + 1;
   localparam logic [CW-1:0]     CLR_LAST  = CW'(RAM_DEPTH - 1);
   localparam logic [CW-1:0]     CPY_LAST  = CW'(COPY_LEN - 1);
   localparam logic [CW-1:0]     DEF_LAST  = CW'(DEF_LEN - 1);
   localparam logic [EE_AW-1:0]  HDR_LAST  = EE_AW'(HDR_BYTES - 1);
   localparam logic [RAM_AW-1:0] BASE      = RAM_AW'(IMG_BASE);

   ld_state_t          state;
   logic [CW-1:0]      cnt;
   logic [EE_AW-1:0]   ee_ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_BOOT;
         cnt      <= '0;
         ee_ptr   <= '0;
         img_path <= 1'b0;
      end else begin
         case (state)
            ST_BOOT: state <= ST_CLEAR;
            ST_CLEAR: begin
               if (cnt == CLR_LAST) begin
                  cnt   <= '0;
                  state <= ST_HDR;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_HDR: begin
               if (ee_ack) begin
                  ee_ptr <= ee_ptr + 1'b1;
                  if (ee_ptr == HDR_LAST) begin
                     img_path <= sig_ok;
                     state    <= sig_ok ? ST_COPY : ST_DEF;
                  end
               end
            end
            ST_COPY: begin
               if (ee_ack) begin
                  ee_ptr <= ee_ptr + 1'b1;
                  cnt    <= cnt + 1'b1;
                  if (cnt == CPY_LAST) state <= ST_FIN;
               end
            end
            ST_DEF: begin
               cnt <= cnt + 1'b1;
               if (cnt == DEF_LAST) state <= ST_FIN;
            end
            ST_FIN:  state <= ST_DONE;
            ST_DONE: state <= ST_DONE;
            default: state <= ST_DONE;
         endcase
      end
   end

   assign ee_req      = (state == ST_HDR) || (state == ST_COPY);
   assign ee_addr     = ee_ptr;
   assign hdr_cap_en  = (state == ST_HDR) && ee_ack;
   assign hdr_cap_idx = ee_ptr[1:0];
   assign def_idx     = cnt[DEF_IW-1:0];
   assign fin         = (state == ST_FIN);
   assign done        = (state == ST_FIN) || (state == ST_DONE);

   always_comb begin
      ram_we    = 1'b0;
      ram_addr  = BASE + cnt[RAM_AW-1:0];
      ram_wdata = 8'h00;
      case (state)
         ST_CLEAR: begin
            ram_we   = 1'b1;
            ram_addr = cnt[RAM_AW-1:0];
         end
         ST_COPY: begin
            ram_we    = ee_ack;
            ram_wdata = ee_data;
         end
         ST_DEF: begin
            ram_we    = 1'b1;
            ram_wdata = def_data;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/cfg_image_loader.sv
module cfg_image_loader
   import cfg_image_loader_pkg::*;
#(
   parameter int unsigned EE_DEPTH    = 8224,
   parameter int unsigned RAM_AW      = 15,
   parameter int unsigned IMG_BASE    = 16384,
   parameter int unsigned RES_MAX     = 384,
   parameter int unsigned DEF_RES_LEN = 19,
   localparam int unsigned EE_AW      = $clog2(EE_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              ee_req,
   output logic [EE_AW-1:0]  ee_addr,
   input  logic              ee_ack,
   input  logic [7:0]        ee_data,
   output logic              ram_we,
   output logic [RAM_AW-1:0] ram_addr,
   output logic [7:0]        ram_wdata,
   output logic [15:0]       res_len,
   output logic              done,
   output logic              upd_pulse
);

   localparam int unsigned RAM_DEPTH = 1 << RAM_AW;
   localparam int unsigned EE_BODY   = EE_DEPTH - HDR_BYTES;
   localparam int unsigned RAM_ROOM  = RAM_DEPTH - IMG_BASE;
   localparam int unsigned COPY_LEN  = (EE_BODY < RAM_ROOM) ? EE_BODY : RAM_ROOM;

   generate
      if (EE_DEPTH < 8) begin : g_chk_ee
         $error("EE_DEPTH too small for a header and body");
      end
      if (IMG_BASE + DEF_LEN > RAM_DEPTH) begin : g_chk_base
         $error("IMG_BASE leaves no room for the default table");
      end
      if (RES_MAX > 65535 || DEF_RES_LEN > 65535) begin : g_chk_len
         $error("length values must fit 16 bits");
      end
      if (COPY_LEN < 1) begin : g_chk_copy
         $error("copy length must be at least one byte");
      end
   endgenerate

   logic              hdr_cap_en;
   logic [1:0]        hdr_cap_idx;
   logic              sig_ok;
   logic [15:0]       len_lim;
   logic [DEF_IW-1:0] def_idx;
   logic [7:0]        def_data;
   logic              img_path;

   cfg_hdr_capture #(
      .RES_MAX (RES_MAX)
   ) u_hdr (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_en   (hdr_cap_en),
      .cap_idx  (hdr_cap_idx),
      .cap_data (ee_data),
      .sig_ok   (sig_ok),
      .len_lim  (len_lim)
   );

   cfg_def_table u_def (
      .idx  (def_idx),
      .data (def_data)
   );

   cfg_load_seq #(
      .EE_AW    (EE_AW),
      .RAM_AW   (RAM_AW),
      .IMG_BASE (IMG_BASE),
      .COPY_LEN (COPY_LEN)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .ee_req      (ee_req),
      .ee_addr     (ee_addr),
      .ee_ack      (ee_ack),
      .ee_data     (ee_data),
      .hdr_cap_en  (hdr_cap_en),
      .hdr_cap_idx (hdr_cap_idx),
      .sig_ok      (sig_ok),
      .def_idx     (def_idx),
      .def_data    (def_data),
      .ram_we      (ram_we),
      .ram_addr    (ram_addr),
      .ram_wdata   (ram_wdata),
      .img_path    (img_path),
      .fin         (upd_pulse),
      .done        (done)
   );

   assign res_len = !done    ? 16'h0000 :
                    img_path ? len_lim  : 16'(DEF_RES_LEN);

endmodule

// File: rtl/cfg_image_loader_chk.sv
module cfg_image_loader_chk #(
   parameter int unsigned EE_DEPTH = 8224,
   parameter int unsigned RAM_AW   = 15,
   parameter int unsigned RES_MAX  = 384,
   localparam int unsigned EE_AW   = $clog2(EE_DEPTH)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ee_req,
   input logic [EE_AW-1:0]  ee_addr,
   input logic              ee_ack,
   input logic              ram_we,
   input logic [15:0]       res_len,
   input logic              done,
   input logic              upd_pulse
);

   localparam logic [EE_AW-1:0] EE_LAST = EE_AW'(EE_DEPTH - 1);
   localparam logic [15:0]      LEN_TOP = 16'(RES_MAX);

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ee_req && !ee_ack) |=> (ee_req && $stable(ee_addr))); // R2

   AST_EE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      ee_req |-> (ee_addr <= EE_LAST)); // R8

   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done); // R6

   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      upd_pulse |=> !upd_pulse); // R6

   AST_PULSE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> upd_pulse); // R6

   AST_QUIET_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!ram_we && !ee_req)); // R6

   AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (res_len <= LEN_TOP)); // R4

   AST_LEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> (res_len == 16'h0000)); // R1

endmodule

bind cfg_image_loader cfg_image_loader_chk #(
   .EE_DEPTH (EE_DEPTH),
   .RAM_AW   (RAM_AW),
   .RES_MAX  (RES_MAX)
) u_chk (.*);

// File: tb/cfg_image_loader_test.sv
module cfg_image_loader_test;

   localparam int EE_D = 48;
   localparam int RAW  = 8;
   localparam int RD   = 256;
   localparam int BASE = 224;
   localparam int RMAX = 384;
   localparam int CPY  = 32;   // min(48-4, 256-224)
   localparam int EAW  = $clog2(EE_D);

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           ee_req;
   logic [EAW-1:0] ee_addr;
   logic           ee_ack = 1'b0;
   logic [7:0]     ee_data = 8'h00;
   logic           ram_we;
   logic [RAW-1:0] ram_addr;
   logic [7:0]     ram_wdata;
   logic [15:0]    res_len;
   logic           done;
   logic           upd_pulse;

   always #10 clk = ~clk;

   cfg_image_loader #(
      .EE_DEPTH (EE_D),
      .RAM_AW   (RAW),
      .IMG_BASE (BASE),
      .RES_MAX  (RMAX)
   ) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .ee_req    (ee_req),
      .ee_addr   (ee_addr),
      .ee_ack    (ee_ack),
      .ee_data   (ee_data),
      .ram_we    (ram_we),
      .ram_addr  (ram_addr),
      .ram_wdata (ram_wdata),
      .res_len   (res_len),
      .done      (done),
      .upd_pulse (upd_pulse)
   );

   logic [7:0] ee_mem [EE_D];
   logic [7:0] ram [RD];
   int ack_lat = 0;
   int wait_cnt = 0;
   int checks = 0;
   int failures = 0;

   // Memory model: one-cycle ack after a programmable wait.
   always @(posedge clk) begin
      if (!rst_n) begin
         ee_ack   <= 1'b0;
         wait_cnt <= 0;
      end else begin
         ee_ack <= 1'b0;
         if (ee_req && !ee_ack) begin
            if (wait_cnt >= ack_lat) begin
               ee_ack   <= 1'b1;
               ee_data  <= ee_mem[ee_addr];
               wait_cnt <= 0;
            end else begin
               wait_cnt <= wait_cnt + 1;
            end
         end
      end
   end

   // Monitor and RAM model, sampled mid-cycle.
   int clr_idx, clr_err, rd_cnt, rd_err, post_err, pulse_cnt;
   always @(negedge clk) begin
      if (!rst_n) begin
         clr_idx = 0; clr_err = 0; rd_cnt = 0; rd_err = 0;
         post_err = 0; pulse_cnt = 0;
         for (int i = 0; i < RD; i++) ram[i] = 8'hA5;
      end else begin
         if (ee_req && clr_idx < RD) clr_err++;
         if (ram_we) begin
            if (clr_idx < RD) begin
               if (int'(ram_addr) != clr_idx || ram_wdata != 8'h00) clr_err++;
               clr_idx++;
            end
            ram[ram_addr] = ram_wdata;
         end
         if (ee_req && ee_ack) begin
            if (int'(ee_addr) != rd_cnt) rd_err++;
            rd_cnt++;
         end
         if (done && (ram_we || ee_req)) post_err++;
         if (upd_pulse) pulse_cnt++;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic set_image(input logic [7:0] b0, input logic [7:0] b1,
                            input logic [7:0] lh, input logic [7:0] ll, input int seed);
      ee_mem[0] = b0; ee_mem[1] = b1; ee_mem[2] = lh; ee_mem[3] = ll;
      for (int k = 4; k < EE_D; k++) ee_mem[k] = 8'((k * 37 + seed * 11 + 5) & 255);
   endtask

   task automatic run_load();
      int n;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      n = 0;
      while (!done && n < 5000) begin
         @(negedge clk);
         n++;
      end
      if (!done) begin
         failures++;
         $display("FAIL watchdog: load did not finish actual=0 expected=1");
      end
      repeat (2) @(negedge clk);
   endtask

   task automatic check_clear_and_fin(input string tag);
      chk(clr_idx == RD && clr_err == 0, {"R1 ordered clear before reads ", tag}, clr_err, 0);
      chk(rd_err == 0, {"R2 consecutive read offsets ", tag}, rd_err, 0);
      chk(pulse_cnt == 1 && post_err == 0, {"R6 single pulse, quiet after done ", tag}, pulse_cnt, 1);
   endtask

   task automatic check_image(input int exp_len, input string tag);
      int bad, zbad;
      bad = 0; zbad = 0;
      for (int i = 0; i < CPY; i++) if (ram[BASE + i] != ee_mem[4 + i]) bad++;
      for (int i = 0; i < BASE; i++) if (ram[i] != 8'h00) zbad++;
      chk(bad == 0, {"R3 image body copied ", tag}, bad, 0);
      chk(zbad == 0, {"R1 region below base cleared ", tag}, zbad, 0);
      chk(rd_cnt == 4 + CPY, {"R3 copy count bounded by RAM room ", tag}, rd_cnt, 4 + CPY);
      chk(int'(res_len) == exp_len, {"R4 resource length ", tag}, int'(res_len), exp_len);
      check_clear_and_fin(tag);
   endtask

   task automatic check_default(input string tag);
      logic [7:0] exp_t [8];
      int bad, zbad;
      exp_t = '{8'h55, 8'hBB, 8'h00, 8'h00, 8'h00, 8'h03, 8'h80, 8'h80};
      bad = 0; zbad = 0;
      for (int i = 0; i < 8; i++) if (ram[BASE + i] != exp_t[i]) bad++;
      for (int i = 0; i < RD; i++)
         if ((i < BASE || i >= BASE + 8) && ram[i] != 8'h00) zbad++;
      chk(bad == 0, {"R5 default table written ", tag}, bad, 0);
      chk(zbad == 0, {"R5 rest of RAM cleared ", tag}, zbad, 0);
      chk(rd_cnt == 4, {"R5 only header read ", tag}, rd_cnt, 4);
      chk(int'(res_len) == 19, {"R5 default length ", tag}, int'(res_len), 19);
      check_clear_and_fin(tag);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk(!done && !upd_pulse && !ee_req && res_len == 16'h0, "R1 reset outputs idle",
          int'(done), 0);
      rst_n = 1'b1;
      repeat (20) @(negedge clk);
      chk(!done && res_len == 16'h0, "R1 length zero while loading", int'(res_len), 0);
   endtask

   task automatic t_valid();
      ack_lat = 0;
      set_image(8'h55, 8'hBB, 8'h00, 8'h10, 1);
      run_load();
      check_image(16, "small length");
   endtask

   task automatic t_endian();
      ack_lat = 2;
      set_image(8'h55, 8'hBB, 8'h01, 8'h02, 2);
      run_load();
      check_image(258, "high byte first");
   endtask

   task automatic t_limit();
      ack_lat = 1;
      set_image(8'h55, 8'hBB, 8'h01, 8'h7F, 3);
      run_load();
      chk(res_len == 16'd383, "R4 just under limit", int'(res_len), 383);
      set_image(8'h55, 8'hBB, 8'h01, 8'h80, 4);
      run_load();
      chk(res_len == 16'd384, "R4 at limit", int'(res_len), 384);
      set_image(8'h55, 8'hBB, 8'h01, 8'h81, 5);
      run_load();
      chk(res_len == 16'd384, "R4 just over limit", int'(res_len), 384);
      set_image(8'h55, 8'hBB, 8'hFF, 8'hFF, 6);
      run_load();
      check_image(384, "all ones length");
   endtask

   task automatic t_no_sig();
      ack_lat = 5;
      set_image(8'h00, 8'h00, 8'h00, 8'h10, 7);
      run_load();
      check_default("blank header");
   endtask

   task automatic t_half_sig();
      ack_lat = 0;
      set_image(8'h55, 8'hBC, 8'h00, 8'h10, 8);
      run_load();
      check_default("R7 second byte wrong");
      set_image(8'hBB, 8'h55, 8'h00, 8'h10, 9);
      run_load();
      check_default("R7 bytes swapped");
   endtask

   task automatic t_hold();
      ack_lat = 3;
      set_image(8'h55, 8'hBB, 8'h00, 8'h20, 10);
      run_load();
      repeat (30) @(negedge clk);
      chk(done == 1'b1, "R6 done stays high", int'(done), 1);
      chk(pulse_cnt == 1 && post_err == 0, "R6 no activity after done", post_err, 0);
      chk(rd_cnt <= EE_D && rd_err == 0, "R8 reads stay inside memory", rd_cnt, 4 + CPY);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: bench did not finish actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      for (int k = 0; k < EE_D; k++) ee_mem[k] = 8'h00;
      t_reset();
      t_valid();
      t_endian();
      t_limit();
      t_no_sig();
      t_half_sig();
      t_hold();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule